// File: doc/BRIEF.md
# Descriptor-Chain Transmit DMA Walker

This block moves a requested number of bytes from memory to a peripheral by following a chain of descriptors kept in RAM. Software hands it a 20-bit link address, a byte count and two option bits, then pulses start. The walker joins the link address with the upper 12 bits of the RAM base to form the first descriptor address. It fetches that descriptor, checks it, and streams the described buffer out one byte at a time on a valid/ready byte port. It then moves on to the next descriptor through the next pointer.

Each descriptor is three consecutive 32-bit words: a control word, the buffer start address, and the address of the next descriptor. In the control word, bit 31 is the owner flag, bit 30 is end-of-frame, bits 23:12 hold the byte length and bits 11:0 a buffer size that the transmit direction does not use. Buffers are read as aligned words, so a buffer may start at any byte and have any length.

Four raw status bits record the outcome and stay set until software clears them. A one-word-at-a-time memory port with a request/acknowledge handshake carries every descriptor fetch, buffer read and write-back.

Top module: `ll_tx_walker`

## Requirements
- R1: While reset is asserted and after it is released, status is 0, busy is 0, and neither mem_req nor tx_valid is asserted.
- R2: The first descriptor address is {RAM_BASE[31:20], link_addr}. cur_dscr holds the address of the descriptor most recently fetched.
- R3: Bytes leave on tx_data in ascending address order, one per tx_valid&tx_ready cycle. The byte at address a is bits 8*a[1:0]+7 down to 8*a[1:0] of the aligned word at a with a[1:0] cleared. From each node the walker sends the smaller of the node length (control bits 23:12) and the bytes still requested.
- R4: The walker advances to the next descriptor only after the current node's whole length has been sent. Once the requested count is reached it fetches no further descriptor.
- R5: When auto_wb is 1, each node whose length is fully sent has its control word written back with bit 31 cleared and the other bits unchanged. When auto_wb is 0, or the node is left unfinished, memory is not written.
- R6: When chk_owner is 1, a fetched descriptor whose control bit 31 is 0 sets the descriptor-error status (bit 3) and ends the transfer without setting done. The next descriptor is fetched and checked only if bytes remain to be sent. When chk_owner is 0, the owner bit is ignored.
- R7: A descriptor address that is not word aligned, or whose three words do not all fall inside [RAM_BASE, RAM_BASE+RAM_BYTES), sets status bit 3 and ends the transfer without a memory access to that descriptor.
- R8: When a fully sent node has control bit 30 set, status bits 1 (end of frame) and 2 (total end of frame) are set and the transfer continues. An unfinished node's bit 30 has no effect.
- R9: A transfer that sends all requested bytes sets status bit 0 (done). An accepted start clears status bits 0 and 1 and leaves bits 2 and 3 unchanged.
- R10: Status bits are sticky. A 1 in status_clr bit i clears status bit i on the next clock.
- R11: start is ignored while busy is 1.
- R12: A byte count of 0 fetches and checks the first descriptor, then sets done without sending any byte.
- R13: While mem_req is high and mem_ack is low, mem_req, mem_addr and mem_we hold. While tx_valid is high and tx_ready is low, tx_valid and tx_data hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted when idle |
| link_addr | input | 20 | Low 20 bits of the first descriptor address |
| byte_count | input | CNT_W | Number of bytes to send |
| chk_owner | input | 1 | Require the owner bit set in each descriptor |
| auto_wb | input | 1 | Write back finished descriptors with owner cleared |
| status_clr | input | 4 | Write-one-to-clear strobes for status |
| status | output | 4 | {dscr_err, total_eof, eof, done} |
| busy | output | 1 | Transfer in progress |
| cur_dscr | output | 32 | Address of the last fetched descriptor |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when 1, read when 0 |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Byte available |
| tx_data | output | 8 | Byte to peripheral |
| tx_ready | input | 1 | Peripheral accepts byte |

## Verification
The hold assertions assume the memory returns one mem_ack per request, never an unrequested one, and that the peripheral may stall freely. The bench memory therefore acknowledges only a pending request, after a random stall, and drops the acknowledge for a cycle after each one. tx_ready toggles pseudo-randomly so that both stalls and back-to-back acceptance occur. The memory model keeps every descriptor and buffer inside the declared RAM window, except in the deliberate out-of-range and misaligned cases.

// File: rtl/ll_tx_walker.sv
module ll_tx_walker #(
  parameter logic [31:0] RAM_BASE  = 32'h3FC8_0000,
  parameter int          RAM_BYTES = 32'h0006_0000,
  parameter int          CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [19:0]      link_addr,
  input  logic [CNT_W-1:0] byte_count,
  input  logic             chk_owner,
  input  logic             auto_wb,
  input  logic [3:0]       status_clr,
  output logic [3:0]       status,
  output logic             busy,
  output logic [31:0]      cur_dscr,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  input  logic             tx_ready
);

  localparam logic [31:0] DSC_LAST = RAM_BASE + 32'(RAM_BYTES) - 32'd12;

  typedef enum logic [2:0] {IDLE, DSC, CHK, XFER, WRD, BYTE, WB, NEND} st_t;

  st_t              state;
  logic [31:0]      dsc, ctl, bufp, nxt, word;
  logic [1:0]       widx;
  logic [CNT_W-1:0] rem;
  logic [11:0]      nrem;
  logic             dsc_ok, go, set_done, set_eof, set_err;

  assign dsc_ok = (dsc[1:0] == 2'b00) && (dsc >= RAM_BASE) && (dsc <= DSC_LAST);
  assign go     = start && (state == IDLE);

  assign busy      = (state != IDLE);
  assign cur_dscr  = dsc;
  assign mem_req   = (state == DSC && dsc_ok) || state == WRD || state == WB;
  assign mem_we    = (state == WB);
  assign mem_addr  = (state == DSC) ? dsc + 32'({widx, 2'b00}) :
                     (state == WRD) ? {bufp[31:2], 2'b00} : dsc;
  assign mem_wdata = {1'b0, ctl[30:0]};
  assign tx_valid  = (state == BYTE);
  assign tx_data   = word[{bufp[1:0], 3'b000} +: 8];

  assign set_done = (state == XFER && rem == '0 && nrem != '0) ||
                    (state == NEND && rem == '0);
  assign set_eof  = (state == NEND) && ctl[30];
  assign set_err  = (state == DSC && !dsc_ok) ||
                    (state == CHK && chk_owner && !ctl[31]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= IDLE;
      status <= '0;
      dsc    <= '0;
      ctl    <= '0;
      bufp   <= '0;
      nxt    <= '0;
      word   <= '0;
      widx   <= '0;
      rem    <= '0;
      nrem   <= '0;
    end else begin
      status <= (status & ~status_clr & ~{2'b00, go, go}) |
                {set_err, set_eof, set_eof, set_done};
      case (state)
        IDLE: if (start) begin
          dsc   <= {RAM_BASE[31:20], link_addr};
          rem   <= byte_count;
          widx  <= '0;
          state <= DSC;
        end
        DSC: begin
          if (!dsc_ok) state <= IDLE;
          else if (mem_ack) begin
            case (widx)
              2'd0: begin ctl <= mem_rdata; nrem <= mem_rdata[23:12]; end
              2'd1: bufp <= mem_rdata;
              default: nxt <= mem_rdata;
            endcase
            widx <= widx + 2'd1;
            if (widx == 2'd2) state <= CHK;
          end
        end
        CHK: state <= (chk_owner && !ctl[31]) ? IDLE : XFER;
        XFER: begin
          if (nrem == '0)     state <= auto_wb ? WB : NEND;
          else if (rem == '0) state <= IDLE;
          else                state <= WRD;
        end
        WRD: if (mem_ack) begin
          word  <= mem_rdata;
          state <= BYTE;
        end
        BYTE: if (tx_ready) begin
          bufp <= bufp + 32'd1;
          nrem <= nrem - 12'd1;
          rem  <= rem - CNT_W'(1);
          if (bufp[1:0] == 2'b11 || nrem == 12'd1 || rem == CNT_W'(1)) state <= XFER;
        end
        WB: if (mem_ack) state <= NEND;
        NEND: begin
          if (rem == '0) state <= IDLE;
          else begin
            dsc   <= nxt;
            widx  <= '0;
            state <= DSC;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !tx_valid));

  // R13
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R13
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R9
  end_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (status[0] || status[3]));

  // R3
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !mem_req);

endmodule

// File: tb/ll_tx_walker_test.sv
module ll_tx_walker_test;
  localparam logic [31:0] B = 32'h3FC8_0000;
  localparam logic [19:0] L = B[19:0];

  logic clk = 0, rst_n = 0, start = 0, chk_owner = 0, auto_wb = 0;
  logic [19:0] link_addr = '0;
  logic [15:0] byte_count = '0;
  logic [3:0]  status_clr = '0, status;
  logic busy, mem_req, mem_we, mem_ack = 0, tx_valid, tx_ready = 0;
  logic [31:0] cur_dscr, mem_addr, mem_wdata, mem_rdata = '0;
  logic [7:0]  tx_data;
  logic [31:0] mem [0:1023];
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0]  q[$];
  int n_chk = 0, n_bad = 0;
  logic hold_p = 0;
  logic [7:0] hold_d = '0;

  always #4 clk = ~clk;

  ll_tx_walker #(.RAM_BASE(B), .RAM_BYTES(4096), .CNT_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .link_addr(link_addr),
    .byte_count(byte_count), .chk_owner(chk_owner), .auto_wb(auto_wb),
    .status_clr(status_clr), .status(status), .busy(busy), .cur_dscr(cur_dscr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready));

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ {a[11:8], 4'h0} ^ 8'h3C;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready <= lfsr[3] | lfsr[6];
    if (!rst_n) mem_ack <= 0;
    else begin
      mem_ack <= 0;
      if (mem_req && !mem_ack && !lfsr[1]) begin
        mem_ack <= 1;
        if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
        else mem_rdata <= mem[mem_addr[11:2]];
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) if (rst_n) begin
    if (hold_p) chk(tx_valid && tx_data == hold_d, "R13 tx hold", {23'b0, tx_valid, tx_data}, {24'h1, hold_d});
    hold_p = tx_valid && !tx_ready;
    hold_d = tx_data;
    if (tx_valid && tx_ready) begin
      if (q.size() == 0) chk(0, "R3 unexpected byte", {24'b0, tx_data}, 32'hxx);
      else begin
        logic [7:0] e;
        e = q.pop_front();
        chk(tx_data == e, "R3 byte value", {24'b0, tx_data}, {24'b0, e});
      end
    end
  end

  task automatic put_dsc(input int off, input int len, input bit eof, input bit own,
                         input int bo, input int no);
    mem[off/4]     = {own, eof, 6'd0, 12'(len), 12'(len)};
    mem[off/4 + 1] = B + 32'(bo);
    mem[off/4 + 2] = B + 32'(no);
  endtask

  task automatic push_exp(input int bo, input int n);
    for (int i = 0; i < n; i++) q.push_back(pat(B + 32'(bo + i)));
  endtask

  task automatic kick(input logic [19:0] la, input int cnt, input bit co, input bit wb);
    @(negedge clk);
    link_addr = la; byte_count = 16'(cnt); chk_owner = co; auto_wb = wb; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    chk(q.size() == 0, "R3 all bytes sent", q.size(), 0);
  endtask

  task automatic clear_all();
    @(negedge clk); status_clr = 4'hF;
    @(negedge clk); status_clr = 4'h0;
  endtask

  initial begin
    #(8 * 150000);
    chk(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int w = 0; w < 1024; w++) begin
      logic [31:0] a;
      a = B + 32'(4 * w);
      mem[w] = {pat(a + 3), pat(a + 2), pat(a + 1), pat(a)};
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(status == 0 && !busy && !mem_req && !tx_valid, "R1 reset", {status, busy, mem_req, tx_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(status == 0 && !busy && !mem_req && !tx_valid, "R1 after reset", {status, busy, mem_req, tx_valid}, 0);

    // single node, write-back, eof (R2 R3 R5 R8 R9)
    put_dsc(32'h100, 8, 1, 1, 32'h400, 32'h200);
    push_exp(32'h400, 8);
    kick(L | 20'h100, 8, 1, 1);
    wait_idle();
    chk(status == 4'b0111, "R8 R9 eof and done", status, 4'b0111);
    chk(mem[32'h100/4] == {1'b0, 1'b1, 6'd0, 12'd8, 12'd8}, "R5 owner cleared", mem[32'h100/4], {8'h40, 12'd8, 12'd8});
    chk(cur_dscr == B + 32'h100, "R2 first address", cur_dscr, B + 32'h100);
    clear_all();
    chk(status == 0, "R10 w1c clear", status, 0);

    // unaligned chain, no write-back (R3 R4 R5)
    put_dsc(32'h120, 5, 1, 1, 32'h501, 32'h140);
    put_dsc(32'h140, 3, 0, 1, 32'h523, 32'h160);
    put_dsc(32'h160, 7, 0, 1, 32'h602, 32'h180);
    push_exp(32'h501, 5); push_exp(32'h523, 3); push_exp(32'h602, 7);
    kick(L | 20'h120, 15, 1, 0);
    wait_idle();
    chk(status == 4'b0111, "R8 mid-chain eof continues", status, 4'b0111);
    chk(mem[32'h120/4][31] == 1'b1, "R5 no write-back", mem[32'h120/4][31], 1);
    chk(cur_dscr == B + 32'h160, "R2 last fetched", cur_dscr, B + 32'h160);

    // short count stops inside second node (R4 R5 R8 R9)
    put_dsc(32'h1A0, 5, 0, 1, 32'h700, 32'h1C0);
    put_dsc(32'h1C0, 5, 1, 1, 32'h710, 32'h1E0);
    push_exp(32'h700, 5); push_exp(32'h710, 1);
    kick(L | 20'h1A0, 6, 1, 1);
    chk(status == 4'b0100, "R9 start clears done/eof only", status, 4'b0100);
    wait_idle();
    chk(status == 4'b0101, "R8 unfinished node eof ignored", status, 4'b0101);
    chk(mem[32'h1A0/4][31] == 0 && mem[32'h1C0/4][31] == 1, "R5 only finished node written",
        {mem[32'h1A0/4][31], mem[32'h1C0/4][31]}, 2'b01);
    chk(cur_dscr == B + 32'h1C0, "R4 no fetch beyond", cur_dscr, B + 32'h1C0);
    clear_all();

    // owner check (R6)
    put_dsc(32'h200, 4, 0, 1, 32'h800, 32'h220);
    put_dsc(32'h220, 4, 0, 0, 32'h810, 32'h240);
    push_exp(32'h800, 4);
    kick(L | 20'h200, 8, 1, 0);
    wait_idle();
    chk(status == 4'b1000, "R6 owner error", status, 4'b1000);
    chk(cur_dscr == B + 32'h220, "R6 failing descriptor", cur_dscr, B + 32'h220);
    clear_all();
    push_exp(32'h800, 4); push_exp(32'h810, 4);
    kick(L | 20'h200, 8, 0, 0);
    wait_idle();
    chk(status == 4'b0001, "R6 owner ignored", status, 4'b0001);
    clear_all();

    // next node not checked once count reached (R6 R4)
    put_dsc(32'h240, 4, 0, 1, 32'h840, 32'h260);
    put_dsc(32'h260, 4, 0, 0, 32'h850, 32'h280);
    push_exp(32'h840, 4);
    kick(L | 20'h240, 4, 1, 0);
    wait_idle();
    chk(status == 4'b0001, "R6 next unchecked", status, 4'b0001);
    chk(cur_dscr == B + 32'h240, "R4 stays on last node", cur_dscr, B + 32'h240);
    clear_all();

    // bad addresses (R7)
    kick(L | 20'h2000, 4, 0, 0);
    wait_idle();
    chk(status == 4'b1000, "R7 out of range", status, 4'b1000);
    clear_all();
    kick(L | 20'h102, 4, 0, 0);
    wait_idle();
    chk(status == 4'b1000, "R7 misaligned", status, 4'b1000);
    clear_all();

    // start while busy (R11)
    push_exp(32'h400, 8);
    kick(L | 20'h100, 8, 0, 0);
    repeat (3) @(negedge clk);
    link_addr = L | 20'h1A0; byte_count = 16'd3; start = 1;
    @(negedge clk); start = 0;
    wait_idle();
    chk(cur_dscr == B + 32'h100 && status == 4'b0111, "R11 start ignored", {cur_dscr[11:0], status}, {12'h100, 4'b0111});
    clear_all();

    // zero count (R12)
    kick(L | 20'h240, 0, 1, 0);
    wait_idle();
    chk(status == 4'b0001, "R12 zero count done", status, 4'b0001);
    chk(cur_dscr == B + 32'h240, "R12 first fetched", cur_dscr, B + 32'h240);

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule